// File: doc/BRIEF.md
# Timer Compare/Capture I/O Channel

This block is one channel of a general-purpose timer. It has a free-running up-counter and two general registers, called A and B. A 3-bit I/O code for each register lives in one 8-bit control register. The code chooses one of two roles for its register.

In compare role, the register is checked against the counter on every enabled clock. On a match, the register's output pin is driven low, driven high or toggled, or left alone. In capture role, the register copies the counter when a chosen edge (rising, falling or either) arrives on the register's input pin, after that pin has passed through a synchronizer.

Software writes the control register and the general registers through simple write strobes and reads them back on the output ports. A per-instance parameter turns the toggle action into a forced-high action for channels that need it.

Top module: `tmr_ioc_chan`

## Requirements
- R1: After reset the counter is 0, both general registers hold all ones, both output pins are 0 and the control register reads 0x00.
- R2: A control write stores data bits 2..0 as the A code and bits 6..4 as the B code, and both take effect on the next clock. The readback shows the A code in bits 2..0 and the B code in bits 6..4, and bits 3 and 7 always read 0.
- R3: The counter increments by one on each clock where `cnt_en` is 1, wraps from all ones to 0, and holds its value while `cnt_en` is 0.
- R4: Code 000 is compare role with no pin action, so a match leaves the pin level unchanged.
- R5: A match occurs on a clock edge where `cnt_en` is 1, the code's top bit is 0, and the counter equals the register value. At that same edge, code 001 sets the pin to 0 and code 010 sets it to 1. There is no match while `cnt_en` is 0.
- R6: Code 011 inverts the pin on each match when `TOGGLE_AS_SET` is 0, and sets the pin to 1 on each match when `TOGGLE_AS_SET` is 1.
- R7: Code 100 captures on a rising input edge, code 101 captures on a falling input edge, and codes 110 and 111 capture on either edge. Suppose the input is sampled at clock edge k with a new level. The register is then loaded at edge k+3 with the counter value that was present just before edge k+3.
- R8: In capture role, software writes to the general register are still accepted. When a capture and a write fall on the same edge, the register takes the captured counter value.
- R9: An output pin changes only on a match. Changing a code, or any clock with no match (including every clock in capture role), leaves the pin level unchanged.
- R10: In compare role, a general register write takes effect on the next clock, and the new value is the one compared from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Counter enable |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register readback |
| gra_we | input | 1 | General register A write strobe |
| grb_we | input | 1 | General register B write strobe |
| gr_wdata | input | CNT_W | Write data for both general registers |
| gra_q | output | CNT_W | General register A value |
| grb_q | output | CNT_W | General register B value |
| cnt_q | output | CNT_W | Counter value |
| cap_in_a | input | 1 | Capture input pin for register A |
| cap_in_b | input | 1 | Capture input pin for register B |
| cmp_out_a | output | 1 | Compare output pin for register A |
| cmp_out_b | output | 1 | Compare output pin for register B |

## Verification
Control writes, register writes, counter steps and compare pin actions all appear one clock after the edge that sees the stimulus. A capture appears three edges after the input pin's new level is first sampled. The bench keeps a reference state that it advances just after each rising edge, using copies of the inputs that were held across that edge. It compares every output against that state at the following falling edge, so each result is checked in the cycle it is due. A capture that coincides with a write is set up by waiting until the reference shows a capture pending, then driving the write into that same cycle.

// File: rtl/tmr_ioc_pkg.sv
package tmr_ioc_pkg;

  localparam int IOC_W  = 3;
  localparam int NUM_GR = 2;
  localparam int CTL_W  = NUM_GR * (IOC_W + 1);

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_ANY  = 2'd2
  } edge_sel_e;

  typedef struct packed {
    logic      cap_mode;
    pin_act_e  act;
    edge_sel_e edge_sel;
  } io_mode_t;

  function automatic io_mode_t decode_io(input logic [IOC_W-1:0] code);
    io_mode_t m;
    m.cap_mode = code[2];
    m.act      = PIN_KEEP;
    m.edge_sel = EDGE_RISE;
    if (!code[2]) begin
      unique case (code[1:0])
        2'b00:   m.act = PIN_KEEP;
        2'b01:   m.act = PIN_LOW;
        2'b10:   m.act = PIN_HIGH;
        default: m.act = PIN_FLIP;
      endcase
    end else begin
      if (code[1])      m.edge_sel = EDGE_ANY;
      else if (code[0]) m.edge_sel = EDGE_FALL;
      else              m.edge_sel = EDGE_RISE;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_ioc_rst_sync.sv
module tmr_ioc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/tmr_ioc_ctl.sv
module tmr_ioc_ctl
  import tmr_ioc_pkg::*;
#(
  parameter int N_FIELD = NUM_GR,
  parameter int FIELD_W = IOC_W
) (
  input  logic                       clk,
  input  logic                       rst_ni,
  input  logic                       wr_en,
  input  logic [N_FIELD*(FIELD_W+1)-1:0] wr_data,
  output logic [N_FIELD*(FIELD_W+1)-1:0] rd_data,
  output logic [N_FIELD-1:0][FIELD_W-1:0] code_q
);

  localparam int SLOT_W = FIELD_W + 1;

  logic [N_FIELD-1:0][FIELD_W-1:0] code_d;

  for (genvar g = 0; g < N_FIELD; g++) begin : g_field
    logic unused_rsvd;
    assign unused_rsvd = wr_data[g*SLOT_W + FIELD_W];

    always_comb begin
      code_d[g] = code_q[g];
      if (wr_en) code_d[g] = wr_data[g*SLOT_W +: FIELD_W];
    end

    assign rd_data[g*SLOT_W +: FIELD_W] = code_q[g];
    assign rd_data[g*SLOT_W + FIELD_W]  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_d;
  end

endmodule

// File: rtl/tmr_ioc_cnt.sv
module tmr_ioc_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/tmr_ioc_edge.sv
module tmr_ioc_edge
  import tmr_ioc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_ni,
  input  logic      pin_in,
  input  logic      cap_mode,
  input  edge_sel_e edge_sel,
  output logic      fire_q
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   prev_q;
  logic                   rise;
  logic                   fall;
  logic                   hit;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_in};
    rise   = sync_q[SYNC_STAGES-1] & ~prev_q;
    fall   = ~sync_q[SYNC_STAGES-1] & prev_q;
    unique case (edge_sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
    hit = hit & cap_mode;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
      fire_q <= hit;
    end
  end

endmodule

// File: rtl/tmr_ioc_gr.sv
module tmr_ioc_gr
  import tmr_ioc_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter bit TOGGLE_AS_SET = 1'b0
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             cap_mode,
  input  pin_act_e         act,
  input  logic             cap_fire,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] gr_q,
  output logic             pin_q
);

  logic [CNT_W-1:0] gr_d;
  logic             pin_d;
  logic             match;
  logic             flip_val;

  if (TOGGLE_AS_SET) begin : g_flip_set
    assign flip_val = 1'b1;
  end else begin : g_flip_inv
    assign flip_val = ~pin_q;
  end

  always_comb begin
    match = cnt_en & ~cap_mode & (cnt_q == gr_q);
    pin_d = pin_q;
    if (match) begin
      unique case (act)
        PIN_LOW:  pin_d = 1'b0;
        PIN_HIGH: pin_d = 1'b1;
        PIN_FLIP: pin_d = flip_val;
        default:  pin_d = pin_q;
      endcase
    end
  end

  always_comb begin
    gr_d = gr_q;
    if (cap_fire && cap_mode) gr_d = cnt_q;
    else if (wr_en)           gr_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      gr_q  <= '1;
      pin_q <= 1'b0;
    end else begin
      gr_q  <= gr_d;
      pin_q <= pin_d;
    end
  end

endmodule

// File: rtl/tmr_ioc_chan.sv
module tmr_ioc_chan
  import tmr_ioc_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter bit TOGGLE_AS_SET = 1'b0,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic             gra_we,
  input  logic             grb_we,
  input  logic [CNT_W-1:0] gr_wdata,
  output logic [CNT_W-1:0] gra_q,
  output logic [CNT_W-1:0] grb_q,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             cap_in_a,
  input  logic             cap_in_b,
  output logic             cmp_out_a,
  output logic             cmp_out_b
);

  logic                          rst_sync_n;
  logic [NUM_GR-1:0][IOC_W-1:0]  code;
  logic [NUM_GR-1:0]             wr_en;
  logic [NUM_GR-1:0]             pin_in;
  logic [NUM_GR-1:0]             pin_out;
  logic [NUM_GR-1:0][CNT_W-1:0]  gr_val;

  assign wr_en  = {grb_we, gra_we};
  assign pin_in = {cap_in_b, cap_in_a};

  tmr_ioc_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tmr_ioc_ctl #(.N_FIELD(NUM_GR), .FIELD_W(IOC_W)) ctl_i (
    .clk     (clk),
    .rst_ni  (rst_sync_n),
    .wr_en   (ctl_we),
    .wr_data (ctl_wdata),
    .rd_data (ctl_rdata),
    .code_q  (code)
  );

  tmr_ioc_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk    (clk),
    .rst_ni (rst_sync_n),
    .en     (cnt_en),
    .cnt_q  (cnt_q)
  );

  for (genvar g = 0; g < NUM_GR; g++) begin : g_unit
    io_mode_t mode;
    logic     fire;

    assign mode = decode_io(code[g]);

    tmr_ioc_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk      (clk),
      .rst_ni   (rst_sync_n),
      .pin_in   (pin_in[g]),
      .cap_mode (mode.cap_mode),
      .edge_sel (mode.edge_sel),
      .fire_q   (fire)
    );

    tmr_ioc_gr #(.CNT_W(CNT_W), .TOGGLE_AS_SET(TOGGLE_AS_SET)) gr_i (
      .clk      (clk),
      .rst_ni   (rst_sync_n),
      .cnt_en   (cnt_en),
      .cnt_q    (cnt_q),
      .cap_mode (mode.cap_mode),
      .act      (mode.act),
      .cap_fire (fire),
      .wr_en    (wr_en[g]),
      .wr_data  (gr_wdata),
      .gr_q     (gr_val[g]),
      .pin_q    (pin_out[g])
    );
  end

  assign gra_q     = gr_val[0];
  assign grb_q     = gr_val[1];
  assign cmp_out_a = pin_out[0];
  assign cmp_out_b = pin_out[1];

endmodule

// File: rtl/tmr_ioc_chan_chk.sv
module tmr_ioc_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic [7:0]       ctl_rdata,
  input logic             gra_we,
  input logic [CNT_W-1:0] gra_q,
  input logic [CNT_W-1:0] grb_q,
  input logic             cmp_out_a,
  input logic             cmp_out_b
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_en |=> (cnt_q == $past(cnt_q) + ONE));                          // R3

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !cnt_en |=> $stable(cnt_q));                                         // R3

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    ctl_we |=> (ctl_rdata == ($past(ctl_wdata) & 8'h77)));               // R2

  AST_CTL_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !ctl_we |=> $stable(ctl_rdata));                                     // R2

  AST_PIN_A_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cnt_en && (cnt_q == gra_q)) |=> $stable(cmp_out_a));               // R9

  AST_PIN_B_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cnt_en && (cnt_q == grb_q)) |=> $stable(cmp_out_b));               // R9

  AST_PIN_A_LOW: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_en && (cnt_q == gra_q) && (ctl_rdata[2:0] == 3'b001))
      |=> !cmp_out_a);                                                   // R5

  AST_PIN_A_HIGH: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_en && (cnt_q == gra_q) && (ctl_rdata[2:0] == 3'b010))
      |=> cmp_out_a);                                                    // R5

  AST_PIN_A_NONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_rdata[2:0] == 3'b000) |=> $stable(cmp_out_a));                  // R4

  AST_GR_A_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (!gra_we && !ctl_rdata[2]) |=> $stable(gra_q));                      // R10

endmodule

bind tmr_ioc_chan tmr_ioc_chan_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_ni    (rst_sync_n),
  .cnt_en    (cnt_en),
  .cnt_q     (cnt_q),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .ctl_rdata (ctl_rdata),
  .gra_we    (gra_we),
  .gra_q     (gra_q),
  .grb_q     (grb_q),
  .cmp_out_a (cmp_out_a),
  .cmp_out_b (cmp_out_b)
);

// File: tb/tmr_ioc_chan_tb_top.sv
module tmr_ioc_chan_tb_top;

  localparam int  CW       = 8;
  localparam time CLK_HALF = 5ns;
  localparam int  WDOG_CYC = 150000;

  logic          clk;
  logic          rst_n;
  logic          cnt_en;
  logic          ctl_we;
  logic [7:0]    ctl_wdata;
  logic          gra_we;
  logic          grb_we;
  logic [CW-1:0] gr_wdata;
  logic          cap_in_a;
  logic          cap_in_b;

  logic [7:0]    rd0, rd1;
  logic [CW-1:0] ga0, gb0, cq0, ga1, gb1, cq1;
  logic          pa0, pb0, pa1, pb1;

  int unsigned n_chk;
  int unsigned n_bad;
  bit          done;
  string       cur_req;

  // reference state
  logic [2:0]    m_code [2];
  logic [CW-1:0] m_cnt;
  logic [CW-1:0] m_gr   [2];
  logic          m_pin  [2][2];  // [variant][unit]
  logic          m_s1   [2];
  logic          m_s2   [2];
  logic          m_prev [2];
  logic          m_fire [2];

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  tmr_ioc_chan #(.CNT_W(CW), .TOGGLE_AS_SET(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(rd0), .gra_we(gra_we), .grb_we(grb_we),
    .gr_wdata(gr_wdata), .gra_q(ga0), .grb_q(gb0), .cnt_q(cq0),
    .cap_in_a(cap_in_a), .cap_in_b(cap_in_b), .cmp_out_a(pa0), .cmp_out_b(pb0)
  );

  tmr_ioc_chan #(.CNT_W(CW), .TOGGLE_AS_SET(1'b1)) dut_set_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(rd1), .gra_we(gra_we), .grb_we(grb_we),
    .gr_wdata(gr_wdata), .gra_q(ga1), .grb_q(gb1), .cnt_q(cq1),
    .cap_in_a(cap_in_a), .cap_in_b(cap_in_b), .cmp_out_a(pa1), .cmp_out_b(pb1)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic edge_hit(input logic [2:0] code, input logic s2, input logic prev);
    logic r, f;
    r = s2 & ~prev;
    f = ~s2 & prev;
    if (!code[2])     return 1'b0;
    if (code[1])      return r | f;
    if (code[0])      return f;
    return r;
  endfunction

  function automatic logic pin_next(input logic [2:0] code, input logic match,
                                    input logic cur, input logic set_var);
    if (!match) return cur;
    case (code)
      3'b001:  return 1'b0;
      3'b010:  return 1'b1;
      3'b011:  return set_var ? 1'b1 : ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic model_reset();
    for (int u = 0; u < 2; u++) begin
      m_code[u] = 3'b000; m_gr[u] = '1;
      m_pin[0][u] = 1'b0; m_pin[1][u] = 1'b0;
      m_s1[u] = 1'b0; m_s2[u] = 1'b0; m_prev[u] = 1'b0; m_fire[u] = 1'b0;
    end
    m_cnt = '0;
  endtask

  task automatic model_step(input logic en, input logic cwe, input logic [7:0] cwd,
                            input logic [1:0] gwe, input logic [CW-1:0] gwd,
                            input logic [1:0] pin);
    logic [2:0]    n_code [2];
    logic [CW-1:0] n_gr   [2];
    logic          n_pin  [2][2];
    logic          n_fire [2];
    for (int u = 0; u < 2; u++) begin
      logic match;
      match = en && !m_code[u][2] && (m_cnt == m_gr[u]);
      n_pin[0][u] = pin_next(m_code[u], match, m_pin[0][u], 1'b0);
      n_pin[1][u] = pin_next(m_code[u], match, m_pin[1][u], 1'b1);
      if (m_fire[u] && m_code[u][2]) n_gr[u] = m_cnt;
      else if (gwe[u])               n_gr[u] = gwd;
      else                           n_gr[u] = m_gr[u];
      n_fire[u] = edge_hit(m_code[u], m_s2[u], m_prev[u]);
      n_code[u] = cwe ? cwd[u*4 +: 3] : m_code[u];
    end
    for (int u = 0; u < 2; u++) begin
      m_prev[u] = m_s2[u];
      m_s2[u]   = m_s1[u];
      m_s1[u]   = pin[u];
      m_fire[u] = n_fire[u];
      m_gr[u]   = n_gr[u];
      m_code[u] = n_code[u];
      m_pin[0][u] = n_pin[0][u];
      m_pin[1][u] = n_pin[1][u];
    end
    if (en) m_cnt = m_cnt + 1'b1;
  endtask

  task automatic check_all(input string req);
    logic [7:0] erd;
    erd = {1'b0, m_code[1], 1'b0, m_code[0]};
    chk(req, "ctl_rdata", rd0, erd);
    chk(req, "ctl_rdata set-variant", rd1, erd);
    chk(req, "cnt_q", cq0, m_cnt);
    chk(req, "gra_q", ga0, m_gr[0]);
    chk(req, "grb_q", gb0, m_gr[1]);
    chk(req, "gra_q set-variant", ga1, m_gr[0]);
    chk(req, "cmp_out_a", pa0, m_pin[0][0]);
    chk(req, "cmp_out_b", pb0, m_pin[0][1]);
    chk(req, "cmp_out_a set-variant", pa1, m_pin[1][0]);
    chk(req, "cmp_out_b set-variant", pb1, m_pin[1][1]);
  endtask

  // one clock: inputs held across the rising edge, checks at the falling edge
  task automatic step();
    logic          en, cwe;
    logic [7:0]    cwd;
    logic [1:0]    gwe, pin;
    logic [CW-1:0] gwd;
    en = cnt_en; cwe = ctl_we; cwd = ctl_wdata;
    gwe = {grb_we, gra_we}; gwd = gr_wdata; pin = {cap_in_b, cap_in_a};
    @(posedge clk);
    #1;
    model_step(en, cwe, cwd, gwe, gwd, pin);
    @(negedge clk);
    check_all(cur_req);
  endtask

  task automatic idle_inputs();
    ctl_we = 1'b0; gra_we = 1'b0; grb_we = 1'b0;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    ctl_we = 1'b1; ctl_wdata = v; step(); ctl_we = 1'b0;
  endtask

  task automatic write_gr(input int u, input logic [CW-1:0] v);
    gr_wdata = v;
    if (u == 0) gra_we = 1'b1; else grb_we = 1'b1;
    step();
    gra_we = 1'b0; grb_we = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0; cur_req = "R1";
    rst_n = 1'b0; cnt_en = 1'b0; ctl_wdata = '0; gr_wdata = '0;
    cap_in_a = 1'b0; cap_in_b = 1'b0;
    idle_inputs();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // control register layout and reserved bits
    cur_req = "R2";
    write_ctl(8'hFF);
    chk("R2", "ctl_rdata reserved bits", int'(rd0 & 8'h88), 0);
    write_ctl(8'h5A);
    chk("R2", "ctl_rdata after 0x5A", rd0, 8'h52);
    write_ctl(8'h00);

    // counter enable, hold and wrap
    cur_req = "R3";
    cnt_en = 1'b1; run(20);
    cnt_en = 1'b0; run(5);
    cnt_en = 1'b1; run(260);

    // code 000: match without action
    cur_req = "R4";
    write_gr(0, m_cnt + 8'd4);
    run(8);

    // codes 001/010 and no match while disabled
    cur_req = "R5";
    write_ctl(8'h12);           // B=001, A=010
    write_gr(0, m_cnt + 8'd3);
    write_gr(1, m_cnt + 8'd3);
    run(6);
    chk("R5", "cmp_out_a after high match", pa0, 1);
    write_ctl(8'h21);           // B=010, A=001
    cnt_en = 1'b0;
    write_gr(0, m_cnt);
    write_gr(1, m_cnt);
    run(4);
    chk("R5", "cmp_out_a held while disabled", pa0, 1);
    cnt_en = 1'b1; run(2);
    chk("R5", "cmp_out_a low after match", pa0, 0);

    // toggle vs forced-high variant
    cur_req = "R6";
    write_ctl(8'h33);
    write_gr(0, m_cnt + 8'd2);
    run(300);
    write_gr(1, m_cnt + 8'd7);
    run(300);

    // code change does not move the pin
    cur_req = "R9";
    write_ctl(8'h44);
    run(3);
    write_ctl(8'h00);
    run(3);

    // capture edges
    cur_req = "R7";
    write_ctl(8'h54);           // B=101 fall, A=100 rise
    cap_in_a = 1'b1; cap_in_b = 1'b1; run(6);
    chk("R7", "gra_q after rise", ga0, m_gr[0]);
    cap_in_a = 1'b0; cap_in_b = 1'b0; run(6);
    chk("R7", "grb_q after fall", gb0, m_gr[1]);
    write_ctl(8'h67);           // B=110, A=111 both edges
    for (int k = 0; k < 8; k++) begin
      cap_in_a = ~cap_in_a; run(2 + k);
      cap_in_b = ~cap_in_b; run(5);
    end

    // capture beats a same-cycle write
    cur_req = "R8";
    write_ctl(8'h44);
    write_gr(0, 8'h11);
    cap_in_a = ~cap_in_a;
    for (int k = 0; k < 8 && !m_fire[0]; k++) step();
    gr_wdata = 8'hA5; gra_we = 1'b1; step(); gra_we = 1'b0;
    chk("R8", "gra_q capture wins", ga0, m_gr[0]);
    run(3);

    // compare-mode write takes effect next clock
    cur_req = "R10";
    write_ctl(8'h00);
    write_gr(0, 8'h3C);
    chk("R10", "gra_q after write", ga0, 8'h3C);

    // constrained random mix
    cur_req = "R9";
    void'($urandom(32'd1234));
    for (int i = 0; i < 6000; i++) begin
      cnt_en   = ($urandom % 8) != 0;
      ctl_we   = ($urandom % 24) == 0;
      ctl_wdata = 8'($urandom);
      gra_we   = ($urandom % 10) == 0;
      grb_we   = ($urandom % 10) == 0;
      gr_wdata = m_cnt + 8'($urandom % 6);
      if (($urandom % 5) == 0) cap_in_a = ~cap_in_a;
      if (($urandom % 5) == 0) cap_in_b = ~cap_in_b;
      step();
    end
    idle_inputs();
    run(4);

    done = 1'b1;
    finish_run();
  end

endmodule